// File: doc/BRIEF.md
# Nibble-Configurable Address/IO Port Controller

This block is the control logic for an 8-bit port. Each 4-bit half can be either general I/O or a carrier of high-order address bits for an external memory bus. The lower half carries address bits 11..8. The upper half, when it is also set to address, carries bits 15..12, so the whole port then carries bits 15..8. A system with a 12-bit external space can therefore keep the upper half as I/O.

The block holds a small mode register and an output data latch. From them it derives a per-bit output enable, a per-bit output value and a per-bit "address selected" flag, which drive the pad logic. The register's reset value depends on the boot mode:
- With no internal program memory, the port wakes up as address lines 15..8.
- Otherwise the whole port wakes up as input.

A float request puts the address-carrying bits into high impedance alongside the memory strobes. A handshake mode uses one outgoing and one incoming control line. The transfer direction follows the upper half's direction bit, and the lower half's direction is forced to agree with it.

Top module: `nibble_port_ctrl`

## Requirements
- R1: When reset is released with `boot_ext`=1, `mode_rd` reads 5'b00011, both halves carry address, `pad_out` equals `bus_addr_hi`, and `pad_oe` is all ones unless `float_req` is high.
- R2: When reset is released with `boot_ext`=0, `mode_rd` reads 0 and `pad_oe` is all zeros (whole port is input).
- R3: Mode bit 0 set: bits 3..0 output `bus_addr_hi[3:0]` with `addr_sel`=1, whatever role the upper half has.
- R4: Mode bit 1 set: bits 7..4 output `bus_addr_hi[7:4]` with `addr_sel`=1, independently of the lower half.
- R5: A half in I/O mode drives its bits of the data latch with `pad_oe` equal to its direction bit (bit 2 lower, bit 3 upper; 1 = output), and `addr_sel`=0. Outside input handshake, `port_rd` equals `pin_in`.
- R6: While `float_req` is high, the `pad_oe` bits of every address-mode half are 0; I/O halves are unaffected.
- R7: When a mode write has bit 4 (handshake on) set, the stored lower direction bit 2 takes the written bit 3, whatever bit 2 was written.
- R8: Output handshake (bits 4 and 3 set): a data write sets `hs_line_o` on the next cycle. With no data write, `hs_peer` high clears it on the next cycle. A data write wins over `hs_peer`.
- R9: Input handshake (bit 4 set, bit 3 clear): a rising `hs_peer` (sampled on `clk`) captures `pin_in`, and `port_rd` returns the captured byte. `hs_line_o` (ready) drops on the next cycle and rises again the cycle after `rd_en`.
- R10: Mode writes never change the data latch. A half kept in I/O mode keeps its output value while the other half changes role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_ext | input | 1 | 1 = no internal program memory (reset to address mode) |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 5 | Mode word: [0] lower addr, [1] upper addr, [2] lower out, [3] upper out, [4] handshake |
| dat_we | input | 1 | Data latch write strobe |
| dat_wdata | input | 8 | Data latch write value |
| rd_en | input | 1 | Read acknowledge of captured input data |
| pin_in | input | 8 | Pad input levels |
| bus_addr_hi | input | 8 | Bus address bits 15..8 |
| float_req | input | 1 | Tri-state request for address bits |
| hs_peer | input | 1 | Peer handshake line (acknowledge or strobe) |
| pad_oe | output | 8 | Per-bit output enable |
| pad_out | output | 8 | Per-bit output value |
| addr_sel | output | 8 | Per-bit address-select flag |
| port_rd | output | 8 | Value returned on a port read |
| mode_rd | output | 5 | Stored mode register |
| hs_line_o | output | 1 | Outgoing handshake line (data available / ready) |

## Verification
The bench uses the default nibble width of 4, which gives the 8-bit port and the 5-bit mode word. This size is small enough for random mode words to reach every combination of address roles, directions and handshake state many times over. Random data, address, float and peer traffic runs on top of those mode words, so each handshake state meets data writes and peer edges in the same cycle. Directed cases cover both reset flavours, the forced lower direction, and a lower half swapped in and out of address use while the upper half holds its data.

// File: rtl/nibble_port_ctrl.sv
module nibble_port_ctrl #(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boot_ext,
  input  logic           cfg_we,
  input  logic [4:0]     cfg_wdata,
  input  logic           dat_we,
  input  logic [2*NIB-1:0] dat_wdata,
  input  logic           rd_en,
  input  logic [2*NIB-1:0] pin_in,
  input  logic [2*NIB-1:0] bus_addr_hi,
  input  logic           float_req,
  input  logic           hs_peer,
  output logic [2*NIB-1:0] pad_oe,
  output logic [2*NIB-1:0] pad_out,
  output logic [2*NIB-1:0] addr_sel,
  output logic [2*NIB-1:0] port_rd,
  output logic [4:0]     mode_rd,
  output logic           hs_line_o
);
  localparam int W = 2 * NIB;

  logic [4:0]   mode_q;
  logic [W-1:0] dat_q;
  logic [W-1:0] in_q;
  logic         avail_q, full_q, peer_q;

  wire hs_out = mode_q[4] & mode_q[3];
  wire hs_in  = mode_q[4] & ~mode_q[3];
  wire rise   = hs_peer & ~peer_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= boot_ext ? 5'b00011 : 5'b00000;
    else if (cfg_we)
      mode_q <= {cfg_wdata[4], cfg_wdata[3],
                 cfg_wdata[4] ? cfg_wdata[3] : cfg_wdata[2],
                 cfg_wdata[1], cfg_wdata[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_we) dat_q <= dat_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      full_q  <= 1'b0;
      in_q    <= '0;
      peer_q  <= 1'b0;
    end else begin
      peer_q <= hs_peer;
      if (!hs_out)      avail_q <= 1'b0;
      else if (dat_we)  avail_q <= 1'b1;
      else if (hs_peer) avail_q <= 1'b0;
      if (!hs_in)       full_q <= 1'b0;
      else if (rise)    full_q <= 1'b1;
      else if (rd_en)   full_q <= 1'b0;
      if (hs_in && rise) in_q <= pin_in;
    end
  end

  for (genvar n = 0; n < 2; n++) begin : g_nib
    wire is_addr = mode_q[n];
    wire is_out  = mode_q[2+n];
    assign pad_oe[n*NIB +: NIB]   = is_addr ? {NIB{~float_req}} : {NIB{is_out}};
    assign pad_out[n*NIB +: NIB]  = is_addr ? bus_addr_hi[n*NIB +: NIB] : dat_q[n*NIB +: NIB];
    assign addr_sel[n*NIB +: NIB] = {NIB{is_addr}};
  end

  assign port_rd   = hs_in ? in_q : pin_in;
  assign mode_rd   = mode_q;
  assign hs_line_o = hs_out ? avail_q : (hs_in & ~full_q);

  // R7
  hs_dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[4] |-> (mode_q[2] == mode_q[3]));

  // R8
  avail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && avail_q && hs_peer && !dat_we && !cfg_we) |=> !hs_line_o);

  // R8
  avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && dat_we && !cfg_we) |=> hs_line_o);

  // R9
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_in && rise && !cfg_we) |=> (port_rd == $past(pin_in) && !hs_line_o));

  // R10
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !dat_we) |=> $stable(dat_q));

  // R6
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (float_req && mode_q[0]) |-> (pad_oe[NIB-1:0] == '0));
endmodule

// File: tb/sim_nibble_port_ctrl.sv
module sim_nibble_port_ctrl;
  logic clk = 0, rst_n = 0, boot_ext = 0;
  logic cfg_we = 0, dat_we = 0, rd_en = 0, float_req = 0, hs_peer = 0;
  logic [4:0] cfg_wdata = 0;
  logic [7:0] dat_wdata = 0, pin_in = 0, bus_addr_hi = 0;
  logic [7:0] pad_oe, pad_out, addr_sel, port_rd;
  logic [4:0] mode_rd;
  logic hs_line_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [4:0] m_mode;
  logic [7:0] m_dat, m_in;
  logic m_avail, m_full, m_peer;

  always #5 clk = ~clk;

  nibble_port_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] e_oe();
    logic [7:0] r;
    for (int n = 0; n < 2; n++)
      r[n*4 +: 4] = m_mode[n] ? {4{~float_req}} : {4{m_mode[2+n]}};
    return r;
  endfunction

  function automatic logic [7:0] e_out();
    logic [7:0] r;
    for (int n = 0; n < 2; n++)
      r[n*4 +: 4] = m_mode[n] ? bus_addr_hi[n*4 +: 4] : m_dat[n*4 +: 4];
    return r;
  endfunction

  function automatic string pad_tag();
    if (float_req && (m_mode[0] || m_mode[1])) return "R6";
    if (m_mode[1]) return "R4";
    if (m_mode[0]) return "R3";
    return "R5";
  endfunction

  task automatic step();
    logic ho, hi, rise;
    #1;
    ho = m_mode[4] & m_mode[3];
    hi = m_mode[4] & ~m_mode[3];
    chk(pad_tag(), pad_oe, e_oe());
    chk(pad_tag(), pad_out, e_out());
    chk("R3", addr_sel, {{4{m_mode[1]}}, {4{m_mode[0]}}});
    chk(hi ? "R9" : "R5", port_rd, hi ? m_in : pin_in);
    chk("R7", {3'b0, mode_rd}, {3'b0, m_mode});
    chk(ho ? "R8" : "R9", {7'b0, hs_line_o}, {7'b0, ho ? m_avail : (hi & ~m_full)});
    @(posedge clk);
    rise = hs_peer & ~m_peer;
    if (!rst_n) begin
      m_mode = boot_ext ? 5'b00011 : 5'b0;
      m_dat = 0; m_in = 0; m_avail = 0; m_full = 0; m_peer = 0;
    end else begin
      m_peer = hs_peer;
      if (!ho) m_avail = 0; else if (dat_we) m_avail = 1; else if (hs_peer) m_avail = 0;
      if (!hi) m_full = 0; else if (rise) m_full = 1; else if (rd_en) m_full = 0;
      if (hi && rise) m_in = pin_in;
      if (dat_we) m_dat = dat_wdata;
      if (cfg_we) m_mode = {cfg_wdata[4], cfg_wdata[3],
                            cfg_wdata[4] ? cfg_wdata[3] : cfg_wdata[2],
                            cfg_wdata[1], cfg_wdata[0]};
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic ext);
    rst_n = 0; boot_ext = ext;
    m_mode = 0; m_dat = 0; m_in = 0; m_avail = 0; m_full = 0; m_peer = 0;
    @(negedge clk);
    @(posedge clk);
    m_mode = ext ? 5'b00011 : 5'b0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle();
    cfg_we = 0; dat_we = 0; rd_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R2
    do_reset(0);
    chk("R2", {3'b0, mode_rd}, 8'h00);
    chk("R2", pad_oe, 8'h00);
    step();
    // R1
    do_reset(1);
    bus_addr_hi = 8'hA5;
    #1;
    chk("R1", {3'b0, mode_rd}, 8'h03);
    chk("R1", pad_out, 8'hA5);
    chk("R1", pad_oe, 8'hFF);
    step();
    float_req = 1; step(); float_req = 0;
    // R10: upper half output I/O, lower swapped between roles
    cfg_we = 1; cfg_wdata = 5'b01100; dat_we = 1; dat_wdata = 8'h3C; step();
    idle();
    cfg_we = 1; cfg_wdata = 5'b01101; step();
    cfg_we = 1; cfg_wdata = 5'b01100; step();
    idle(); #1;
    chk("R10", pad_out, 8'h3C);
    step();
    // R7: handshake on, upper output, lower written as input
    cfg_we = 1; cfg_wdata = 5'b11000; step(); idle(); #1;
    chk("R7", {3'b0, mode_rd}, 8'h1C);
    // R8: output handshake
    dat_we = 1; dat_wdata = 8'h77; step(); idle(); #1;
    chk("R8", {7'b0, hs_line_o}, 8'h01);
    hs_peer = 1; step(); hs_peer = 0; #1;
    chk("R8", {7'b0, hs_line_o}, 8'h00);
    step();
    // R9: input handshake
    cfg_we = 1; cfg_wdata = 5'b10100; step(); idle(); #1;
    chk("R7", {3'b0, mode_rd}, 8'h10);
    pin_in = 8'hC3; hs_peer = 1; step(); hs_peer = 0; pin_in = 8'h11; #1;
    chk("R9", port_rd, 8'hC3);
    chk("R9", {7'b0, hs_line_o}, 8'h00);
    rd_en = 1; step(); rd_en = 0; #1;
    chk("R9", {7'b0, hs_line_o}, 8'h01);
    step();
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      cfg_we      = ($urandom % 8) == 0;
      cfg_wdata   = 5'($urandom);
      dat_we      = ($urandom % 4) == 0;
      dat_wdata   = 8'($urandom);
      rd_en       = ($urandom % 3) == 0;
      pin_in      = 8'($urandom);
      bus_addr_hi = 8'($urandom);
      float_req   = ($urandom % 5) == 0;
      hs_peer     = ($urandom % 2) == 0;
      step();
      if (i % 1500 == 1499) begin
        idle();
        do_reset(1'($urandom));
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule